// File: doc/BRIEF.md
# Bit-Serial Adder with Same-Cycle Restart

This block adds two unsigned numbers that arrive one bit per clock, least significant bit first. Every cycle it consumes one bit of each operand and returns one bit of the sum in that same cycle. A single flip-flop carries the carry from one bit position to the next. The block needs one full-adder cell and one register, whatever the operand length.

A restart input marks the current cycle as bit zero of a new addition. The restart takes effect at once. In the cycle where restart is high, the stored carry is masked to zero before it reaches the adder, so the sum bit of that cycle is already the first bit of the new result. The carry produced in that cycle is stored as usual. Nothing outside the block frames the operands: the user raises restart on the first bit of each addition and keeps streaming bits after it. Until the first restart the output has no defined value.

Top module: `bsa_serial_adder`

## Requirements
- R1: For every cycle i at or after the most recent restart cycle r, the sum bits from r to i, read with bit r as the least significant, equal (A + B) mod 2^(i-r+1), where A and B are formed the same way from the operand bits of those cycles.
- R2: The sum output is combinational. It is opa XOR opb XOR the effective carry-in, and it is valid in the same cycle as those operand bits.
- R3: In a cycle with restart = 1, the effective carry-in is 0 and the sum equals opa XOR opb, whatever carry was stored before.
- R4: Outside a restart cycle, when opa = opb = 1, the effective carry-in of the next cycle is 1 (carry generate).
- R5: When opa = opb = 0, the effective carry-in of the next cycle is 0, unless that next cycle is itself a restart (carry kill).
- R6: Outside a restart cycle, when opa differs from opb, the effective carry-in of the next cycle equals that of the current cycle (carry propagate).
- R7: The carry produced in a restart cycle is kept. A restart with opa = opb = 1 gives sum 0 in that cycle and a carry-in of 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the carry register updates on the rising edge |
| restart | input | 1 | Marks the current cycle as bit zero of a new addition |
| opa | input | 1 | Current bit of operand A, LSB first |
| opb | input | 1 | Current bit of operand B, LSB first |
| sum | output | 1 | Current sum bit, combinational |

## Verification
Random frames of 1 to 40 bits, with random operand bits, check the bit-by-bit result against a reference integer sum that is cleared at each restart. Long runs of ones on both operands exercise carry generate and carry ripple. Runs of 0 plus 1 show whether a carry propagates without change. Directed sequences then raise restart while a carry is stored, raise restart on consecutive cycles, and raise restart with both operand bits high. These separate a restart that masks the carry in the same cycle from one that only clears the register for the next cycle, and they show whether the carry produced in a restart cycle is kept.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    // Registered state of the serial adder: only the stored carry.
    typedef struct packed {
        logic carry;
    } bsa_state_t;

    localparam bsa_state_t BSA_STATE_ZERO = '{carry: 1'b0};

endpackage

// File: rtl/bsa_carry_gate.sv
// Selects the effective carry-in: the stored carry, or zero in a restart cycle.
module bsa_carry_gate (
    input  logic stored_carry,
    input  logic restart,
    output logic carry_in
);
    always_comb begin
        carry_in = stored_carry & ~restart;
    end
endmodule

// File: rtl/bsa_full_adder.sv
// One-bit full adder cell.
module bsa_full_adder (
    input  logic x,
    input  logic y,
    input  logic cin,
    output logic s,
    output logic cout
);
    always_comb begin
        s    = x ^ y ^ cin;
        cout = (x & y) | (cin & (x ^ y));
    end
endmodule

// File: rtl/bsa_serial_adder.sv
// Bit-serial adder, LSB first, with a restart that acts in the same cycle.
module bsa_serial_adder
    import bsa_pkg::*;
(
    input  logic clk,
    input  logic restart,
    input  logic opa,
    input  logic opb,
    output logic sum
);

    bsa_state_t state_d, state_q;
    logic       carry_eff;
    logic       sum_bit;
    logic       carry_out;

    bsa_carry_gate u_gate (
        .stored_carry (state_q.carry),
        .restart      (restart),
        .carry_in     (carry_eff)
    );

    bsa_full_adder u_fa (
        .x    (opa),
        .y    (opb),
        .cin  (carry_eff),
        .s    (sum_bit),
        .cout (carry_out)
    );

    always_comb begin
        state_d       = state_q;
        state_d.carry = carry_out;
        sum           = sum_bit;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // ---------------- assertions ----------------
    // armed_q: a restart has been seen, so the stored state is defined.
    logic armed_q = 1'b0;
    always_ff @(posedge clk) begin
        if (restart) armed_q <= 1'b1;
    end

    // R3: a restart cycle ignores the stored carry.
    a_r3_restart_masks_carry: assert property (@(posedge clk)
        restart |-> (sum == (opa ^ opb)));

    // R4: generate sets the next carry-in.
    a_r4_generate: assert property (@(posedge clk) disable iff (!armed_q)
        (!restart && opa && opb) |=> (restart || ((sum ^ opa ^ opb) == 1'b1)));

    // R5: kill clears the next carry-in.
    a_r5_kill: assert property (@(posedge clk) disable iff (!armed_q)
        (!opa && !opb) |=> (restart || ((sum ^ opa ^ opb) == 1'b0)));

    // R6: propagate keeps the carry-in (carry-in = NOT previous sum when a != b).
    a_r6_propagate: assert property (@(posedge clk) disable iff (!armed_q)
        (!restart && (opa != opb)) |=> (restart || ((sum ^ opa ^ opb) == !$past(sum))));

    // R7: the carry produced in a restart cycle is kept.
    a_r7_restart_carry_kept: assert property (@(posedge clk)
        (restart && opa && opb) |=> (restart || ((sum ^ opa ^ opb) == 1'b1)));

endmodule

// File: tb/bsa_serial_adder_bench.sv
module bsa_serial_adder_bench;

    logic clk = 1'b0;
    logic restart = 1'b0;
    logic opa = 1'b0;
    logic opb = 1'b0;
    logic sum;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    longint unsigned acc_a = 0;
    longint unsigned acc_b = 0;
    int              idx   = 0;

    always #5 clk = ~clk;

    bsa_serial_adder u_bsa_serial_adder (
        .clk     (clk),
        .restart (restart),
        .opa     (opa),
        .opb     (opb),
        .sum     (sum)
    );

    function automatic logic exp_bit(longint unsigned va, longint unsigned vb, int pos);
        longint unsigned t;
        t = va + vb;
        return logic'((t >> pos) & 64'd1);
    endfunction

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s bit %0d: actual=%0b expected=%0b", tag, idx, act, exp);
        end
    endtask

    // Drive one cycle away from the rising edge, check the sum before the edge.
    task automatic step(string tag, logic r, logic a, logic b);
        @(negedge clk);
        restart = r;
        opa = a;
        opb = b;
        if (r) begin
            acc_a = 0;
            acc_b = 0;
            idx = 0;
        end
        acc_a = acc_a | (longint'(a) << idx);
        acc_b = acc_b | (longint'(b) << idx);
        #2;
        check(tag, sum, exp_bit(acc_a, acc_b, idx));
        idx++;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));

        // R3: the first restart gives sum = a ^ b.
        step("R3", 1'b1, 1'b1, 1'b0);
        // R2/R6: propagate with carry 0.
        step("R2", 1'b0, 1'b0, 1'b1);

        // R4: a long carry chain, all ones plus all ones.
        step("R3", 1'b1, 1'b1, 1'b1);
        for (int k = 0; k < 10; k++) step("R4", 1'b0, 1'b1, 1'b1);
        // R6: propagate a stored carry of 1.
        for (int k = 0; k < 4; k++) step("R6", 1'b0, 1'b1, 1'b0);
        // R5: kill, then propagate a carry of 0.
        step("R5", 1'b0, 1'b0, 1'b0);
        step("R5", 1'b0, 1'b0, 1'b1);

        // R3: restart while a carry is stored (after a generate).
        step("R1", 1'b1, 1'b0, 1'b0);
        step("R4", 1'b0, 1'b1, 1'b1);
        step("R3", 1'b1, 1'b0, 1'b0);   // expect 0, not 1
        step("R3", 1'b1, 1'b0, 1'b1);   // back-to-back restarts
        step("R3", 1'b1, 1'b1, 1'b0);

        // R7: restart with both bits high keeps its carry.
        step("R7", 1'b1, 1'b1, 1'b1);   // expect 0
        step("R7", 1'b0, 1'b0, 1'b0);   // expect 1
        step("R7", 1'b1, 1'b1, 1'b1);
        step("R7", 1'b0, 1'b1, 1'b0);   // expect 0, carry still 1
        step("R7", 1'b0, 1'b0, 1'b0);   // expect 1

        // R1: random frames.
        for (int f = 0; f < 300; f++) begin
            int len;
            len = 1 + int'($urandom_range(39, 0));
            for (int k = 0; k < len; k++)
                step("R1", (k == 0), logic'($urandom_range(1, 0)), logic'($urandom_range(1, 0)));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule